// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by walking a two-level page table tree held in memory. A root register holds the byte address of the outer table. The top 12 bits of the virtual address pick one outer entry, and that entry points at an inner table. The next 8 bits pick an entry in that inner table, which supplies an 18-bit physical page number. The low 12 bits pass through unchanged as the page offset.

Requests arrive on a valid/ready handshake, one at a time. The walker issues the two table reads in order on a memory read port that never has more than one read in flight, because the inner read address depends on the data the outer read returns. Each table entry is a 32-bit word with a valid flag in bit 31. If either entry is invalid, the walk ends with a fault response instead of an address. The root register can be written at any time, but the write takes effect only while no walk is in progress.

Top module: `pt2_walker`

## Requirements
- R1: While reset is asserted and on leaving it, `req_ready` is 1 and both `mem_rd_valid` and `rsp_valid` are 0. The root register resets to the `ROOT_RESET` parameter, which defaults to 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when no walk is in progress, so it is 0 from the cycle after acceptance until the response has been taken.
- R3: The first read of a walk is at byte address root + 4 × vaddr[31:20], taken modulo 2^30.
- R4: Once `mem_rd_valid` is raised, it and `mem_rd_addr` stay unchanged until a cycle in which `mem_rd_ready` is 1.
- R5: In an outer entry, bit 31 set marks the entry valid and bits [29:0] give the inner table base. The second read is at inner base + 4 × vaddr[19:12], taken modulo 2^30. Bit 30 of the outer entry is ignored.
- R6: At most one read is outstanding. The second read is requested only after the response to the first has arrived. A `mem_rsp_valid` pulse while no read is outstanding is ignored.
- R7: When the inner entry has bit 31 set, the response has `rsp_fault` = 0 and `rsp_paddr` = {entry[17:0], vaddr[11:0]}. Entry bits [30:18] are ignored.
- R8: When the outer entry has bit 31 clear, the walk issues no second read and responds with `rsp_fault` = 1 and `rsp_paddr` = 0.
- R9: When the inner entry has bit 31 clear, the response has `rsp_fault` = 1 and `rsp_paddr` = 0.
- R10: `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged until `rsp_ready` is 1. The walker then becomes ready for a new request in the next cycle.
- R11: A root write (`root_we` = 1) takes effect only while `req_ready` is 1. A request accepted on the same edge as a root write walks from the new root. A write made while a walk is in progress is dropped.
- R12: Walks are served strictly in the order they were accepted, with one response per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Root register write strobe |
| root_wdata | input | 30 | New outer table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Table read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 30 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle per read |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 30 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Walk hit an invalid entry |

## Verification
The bench places one inner table base just below 2^30 and sets the root near the top of the space, so both entry-address sums wrap. A walker that kept a carry or added the index unscaled would read the wrong word and return a mismatched physical address. It writes the root in the middle of a walk and again on the very edge a request is accepted. A design that took the first write would fault on the next walk, and one that latched the root a cycle late would read from the old table. Outer entries with the valid bit clear but a nonzero pointer field must end the walk after one read: an extra read trips the expected-read queue. Junk in bits 30 and [30:18] of the entries, together with stray read-data pulses between reads, exposes a walker that masks fields loosely or samples data when no read is outstanding.

// File: rtl/pt2_pkg.sv
package pt2_pkg;

    // Walk sequence: at most one table read in flight at any time.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_RESP    = 3'd5
    } walk_state_e;

    function automatic logic is_busy(input walk_state_e st);
        return st != ST_IDLE;
    endfunction

endpackage

// File: rtl/pt2_entry_addr.sv
// Entry byte address = table base + index scaled by the entry size, wrapping
// in the physical address width.
module pt2_entry_addr #(
    parameter int ADDR_W     = 30,
    parameter int IDX_W      = 12,
    parameter int SIZE_LOG2  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext = ADDR_W'(idx);

    generate
        if (SIZE_LOG2 == 0) begin : g_byte_entries
            assign addr = base + idx_ext;
        end else begin : g_scaled_entries
            assign addr = base + (idx_ext << SIZE_LOG2);
        end
    endgenerate
endmodule

// File: rtl/pt2_entry_decode.sv
// Splits a table word into its valid flag and its payload field.
module pt2_entry_decode #(
    parameter int WORD_W    = 32,
    parameter int FIELD_W   = 30,
    parameter int VALID_BIT = 31
) (
    input  logic [WORD_W-1:0]  word,
    output logic               ok,
    output logic [FIELD_W-1:0] field
);
    localparam logic [WORD_W-1:0] FIELD_MASK = WORD_W'((64'd1 << FIELD_W) - 64'd1);
    localparam logic [WORD_W-1:0] USED_MASK  = FIELD_MASK | (WORD_W'(1) << VALID_BIT);

    logic unused_rsvd;

    assign ok          = word[VALID_BIT];
    assign field       = word[FIELD_W-1:0];
    assign unused_rsvd = ^(word & ~USED_MASK);
endmodule

// File: rtl/pt2_va_fields.sv
// Carves the virtual address into outer index, inner index and page offset,
// each widened to a common index width for the shared address generator.
module pt2_va_fields #(
    parameter int VA_W    = 32,
    parameter int OUTER_W = 12,
    parameter int INNER_W = 8,
    parameter int OFF_W   = 12,
    parameter int IDX_W   = 12
) (
    input  logic [VA_W-1:0]  va,
    output logic [IDX_W-1:0] outer_idx,
    output logic [IDX_W-1:0] inner_idx,
    output logic [OFF_W-1:0] offset
);
    assign outer_idx = IDX_W'(va[VA_W-1 -: OUTER_W]);
    assign inner_idx = IDX_W'(va[OFF_W +: INNER_W]);
    assign offset    = va[OFF_W-1:0];
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
    import pt2_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int OUTER_W    = 12,
    parameter int INNER_W    = 8,
    parameter int OFF_W      = 12,
    parameter int PA_W       = 30,
    parameter int PPN_W      = 18,
    parameter int WORD_W     = 32,
    parameter int SIZE_LOG2  = 2,
    parameter int VALID_BIT  = 31,
    parameter logic [PA_W-1:0] ROOT_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_we,
    input  logic [PA_W-1:0]   root_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault
);
    localparam int IDX_W = (OUTER_W > INNER_W) ? OUTER_W : INNER_W;

    typedef struct packed {
        walk_state_e     st;
        logic [PA_W-1:0] root;
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] inner_base;
        logic [PA_W-1:0] paddr;
        logic            fault;
    } walk_t;

    walk_t s_d, s_q;

    logic [IDX_W-1:0]  outer_idx, inner_idx, sel_idx;
    logic [OFF_W-1:0]  page_off;
    logic [PA_W-1:0]   sel_base;
    logic [PA_W-1:0]   root_q;
    logic              outer_ok, inner_ok;
    logic [PA_W-1:0]   outer_ptr;
    logic [PPN_W-1:0]  inner_ppn;
    logic              second_level;

    assign root_q       = s_q.root;
    assign second_level = (s_q.st == ST_L2_REQ);

    pt2_va_fields #(
        .VA_W(VA_W), .OUTER_W(OUTER_W), .INNER_W(INNER_W),
        .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_fields (
        .va        (s_q.va),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (page_off)
    );

    assign sel_base = second_level ? s_q.inner_base : root_q;
    assign sel_idx  = second_level ? inner_idx : outer_idx;

    pt2_entry_addr #(
        .ADDR_W(PA_W), .IDX_W(IDX_W), .SIZE_LOG2(SIZE_LOG2)
    ) u_addr (
        .base (sel_base),
        .idx  (sel_idx),
        .addr (mem_rd_addr)
    );

    pt2_entry_decode #(
        .WORD_W(WORD_W), .FIELD_W(PA_W), .VALID_BIT(VALID_BIT)
    ) u_outer_dec (
        .word  (mem_rsp_data),
        .ok    (outer_ok),
        .field (outer_ptr)
    );

    pt2_entry_decode #(
        .WORD_W(WORD_W), .FIELD_W(PPN_W), .VALID_BIT(VALID_BIT)
    ) u_inner_dec (
        .word  (mem_rsp_data),
        .ok    (inner_ok),
        .field (inner_ppn)
    );

    assign req_ready    = !is_busy(s_q.st);
    assign mem_rd_valid = (s_q.st == ST_L1_REQ) || (s_q.st == ST_L2_REQ);
    assign rsp_valid    = (s_q.st == ST_RESP);
    assign rsp_paddr    = s_q.paddr;
    assign rsp_fault    = s_q.fault;

    always_comb begin
        s_d = s_q;

        // Root updates are only honoured between walks.
        if (root_we && !is_busy(s_q.st)) begin
            s_d.root = root_wdata;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.va    = req_vaddr;
                    s_d.paddr = '0;
                    s_d.fault = 1'b0;
                    s_d.st    = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                if (mem_rd_ready) begin
                    s_d.st = ST_L1_WAIT;
                end
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (outer_ok) begin
                        s_d.inner_base = outer_ptr;
                        s_d.st         = ST_L2_REQ;
                    end else begin
                        s_d.fault = 1'b1;
                        s_d.paddr = '0;
                        s_d.st    = ST_RESP;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_rd_ready) begin
                    s_d.st = ST_L2_WAIT;
                end
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (inner_ok) begin
                        s_d.paddr = {inner_ppn, page_off};
                        s_d.fault = 1'b0;
                    end else begin
                        s_d.paddr = '0;
                        s_d.fault = 1'b1;
                    end
                    s_d.st = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st         <= ST_IDLE;
            s_q.root       <= ROOT_RESET;
            s_q.va         <= '0;
            s_q.inner_base <= '0;
            s_q.paddr      <= '0;
            s_q.fault      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

module pt2_walker_chk #(
    parameter int PA_W = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rsp_valid,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            root_we,
    input logic [PA_W-1:0] root_q
);
    logic rd_open_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_open_q <= 1'b0;
        end else if (mem_rd_valid && mem_rd_ready) begin
            rd_open_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            rd_open_q <= 1'b0;
        end
    end

    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (mem_rd_valid || rsp_valid)));

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && mem_rd_valid));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R6
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || rsp_valid) |-> !rd_open_q);

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R10
    rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

    // R11
    root_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (root_we && !req_ready) |=> $stable(root_q));
endmodule

bind pt2_walker pt2_walker_chk #(.PA_W(PA_W)) u_pt2_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .root_we       (root_we),
    .root_q        (root_q)
);

// File: tb/pt2_walker_bench.sv
module pt2_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [29:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [29:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [29:0] rsp_paddr;
    logic        rsp_fault;

    always #2 clk = ~clk;

    pt2_walker u_pt2_walker (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    typedef struct { logic [29:0] addr; int lvl; } rd_exp_t;
    typedef struct { logic fault; logic [29:0] paddr; string tag; } rsp_exp_t;

    logic [31:0] mem [logic [29:0]];
    rd_exp_t     rd_q[$];
    rsp_exp_t    rsp_q[$];
    logic [29:0] root_m = '0;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    bit          spurious_en = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [29:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Scoreboard driver: predicts reads and result, then drives the request.
    task automatic translate(input logic [31:0] va, input bit with_root, input logic [29:0] new_root,
                             input string tag);
        logic [29:0] a1, a2;
        logic [31:0] w1, w2;
        rsp_exp_t    e;
        if (with_root) root_m = new_root;
        a1 = root_m + {16'b0, va[31:20], 2'b00};
        w1 = rd_word(a1);
        rd_q.push_back('{addr: a1, lvl: 1});
        e.tag = tag;
        if (!w1[31]) begin
            e.fault = 1'b1; e.paddr = '0;
        end else begin
            a2 = w1[29:0] + {20'b0, va[19:12], 2'b00};
            w2 = rd_word(a2);
            rd_q.push_back('{addr: a2, lvl: 2});
            if (w2[31]) begin
                e.fault = 1'b0; e.paddr = {w2[17:0], va[11:0]};
            end else begin
                e.fault = 1'b1; e.paddr = '0;
            end
        end
        rsp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        if (with_root) begin
            root_we = 1'b1; root_wdata = new_root;
        end
        @(negedge clk);
        req_valid = 1'b0;
        root_we = 1'b0;
        // R2: busy right after acceptance
        chk(req_ready == 1'b0, "R2 ready after accept", {31'b0, req_ready}, 32'h0);
    endtask

    task automatic root_write(input logic [29:0] val);
        @(negedge clk);
        root_we = 1'b1;
        root_wdata = val;
        if (req_ready) root_m = val;   // R11: only idle writes count
        @(negedge clk);
        root_we = 1'b0;
    endtask

    task automatic drain();
        while (rsp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0, "R8 no extra read pending", rd_q.size(), 0);
    endtask

    // Memory responder: backpressure, variable latency, stray data pulses.
    initial begin
        bit          pend = 1'b0;
        int          lat = 0;
        int          rdy_wait = 1;
        bit          prev_wait = 1'b0;
        logic [29:0] prev_addr = '0;
        logic [29:0] open_addr = '0;
        rd_exp_t     x;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'h0;
            if (prev_wait) begin
                chk(mem_rd_valid && (mem_rd_addr == prev_addr), "R4 read held",
                    {2'b0, mem_rd_addr}, {2'b0, prev_addr});
            end
            if (mem_rd_valid) begin
                chk(!pend, "R6 read while outstanding", {31'b0, pend}, 32'h0);
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd_word(open_addr);
                    pend = 1'b0;
                end else begin
                    lat--;
                end
            end else if (spurious_en && rst_n && (cyc % 5 == 0)) begin
                mem_rsp_valid = 1'b1;         // R6: must be ignored
                mem_rsp_data  = 32'hFFFF_FFFF;
            end
            mem_rd_ready = 1'b0;
            prev_wait = 1'b0;
            if (mem_rd_valid && !pend && !mem_rsp_valid) begin
                if (rdy_wait == 0) begin
                    mem_rd_ready = 1'b1;
                    if (rd_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected read", {2'b0, mem_rd_addr}, 32'h0);
                    end else begin
                        x = rd_q.pop_front();
                        chk(mem_rd_addr == x.addr, (x.lvl == 1) ? "R3 outer addr" : "R5 inner addr",
                            {2'b0, mem_rd_addr}, {2'b0, x.addr});
                    end
                    pend = 1'b1;
                    open_addr = mem_rd_addr;
                    lat = cyc % 3;
                    rdy_wait = cyc % 2;
                end else begin
                    rdy_wait--;
                    prev_wait = 1'b1;
                    prev_addr = mem_rd_addr;
                end
            end else if (mem_rd_valid) begin
                prev_wait = 1'b1;
                prev_addr = mem_rd_addr;
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        bit          held = 1'b0;
        logic [29:0] h_pa = '0;
        logic        h_f = 1'b0;
        rsp_exp_t    e;
        forever begin
            @(negedge clk);
            rsp_ready = (cyc % 4 != 1);
            #1;
            if (held) begin
                chk(rsp_valid && rsp_paddr == h_pa && rsp_fault == h_f, "R10 response held",
                    {1'b0, rsp_fault, rsp_paddr}, {1'b0, h_f, h_pa});
            end
            held = 1'b0;
            if (rsp_valid) begin
                if (rsp_ready) begin
                    if (rsp_q.size() == 0) begin
                        chk(1'b0, "R12 response without request", {2'b0, rsp_paddr}, 32'h0);
                    end else begin
                        e = rsp_q.pop_front();
                        chk(rsp_fault == e.fault && rsp_paddr == e.paddr, e.tag,
                            {1'b0, rsp_fault, rsp_paddr}, {1'b0, e.fault, e.paddr});
                    end
                end else begin
                    held = 1'b1; h_pa = rsp_paddr; h_f = rsp_fault;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired pending=%0d", rsp_q.size());
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        // Root-0 outer table
        mem[30'h0000_0000] = 32'h8010_0000;           // idx 0x000 -> 0x0010_0000
        mem[30'h0000_0014] = 32'hC020_0000;           // idx 0x005, bit30 junk
        mem[30'h0000_3FFC] = 32'hBFFF_FF00;           // idx 0xFFF -> base near top
        mem[30'h0000_001C] = 32'h0030_0000;           // idx 0x007 invalid, nonzero field
        mem[30'h0000_0024] = 32'h8040_0000;           // idx 0x009
        mem[30'h0000_0FFC] = 32'h8060_0000;           // reached via wrapped root
        // Inner entries
        mem[30'h0010_0000] = 32'h8000_0001;
        mem[30'h0010_03FC] = 32'hFFFF_FFFF;           // ppn 3FFFF with junk
        mem[30'h0020_0048] = 32'h802A_AAAA;
        mem[30'h0000_0100] = 32'h8001_5555;           // wrapped inner address
        mem[30'h0040_000C] = 32'h0001_2345;           // invalid inner
        mem[30'h0060_0004] = 32'h8000_BEEF;
        // Second root table
        mem[30'h0100_0008] = 32'h8050_0000;
        mem[30'h0050_0010] = 32'h8000_0777;

        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 reset req_ready", {31'b0, req_ready}, 1);
        chk(mem_rd_valid == 1'b0, "R1 reset mem_rd_valid", {31'b0, mem_rd_valid}, 0);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", {31'b0, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !mem_rd_valid && !rsp_valid, "R1 after reset",
            {29'b0, req_ready, mem_rd_valid, rsp_valid}, 32'h4);

        translate(32'h000_00_ABC, 1'b0, '0, "R7 R1 walk from reset root");
        translate(32'h000_FF_FFF, 1'b0, '0, "R7 junk bits ignored");
        translate(32'h005_12_123, 1'b0, '0, "R5 R7 outer bit30 ignored");
        translate(32'hFFF_80_456, 1'b0, '0, "R5 inner address wraps");
        translate(32'h007_44_000, 1'b0, '0, "R8 invalid outer");
        translate(32'h009_03_321, 1'b0, '0, "R9 invalid inner");
        translate(32'h123_00_001, 1'b0, '0, "R8 empty outer slot");
        drain();

        translate(32'h000_00_111, 1'b0, '0, "R12 in-order walk");
        root_write(30'h0123_4000);                    // busy: dropped
        translate(32'h005_12_FED, 1'b0, '0, "R11 busy root write dropped");
        drain();

        root_write(30'h0100_0000);                    // idle: taken
        translate(32'h002_04_0F0, 1'b0, '0, "R11 idle root write");
        drain();

        translate(32'h7FF_01_777, 1'b1, 30'h3FFF_F000, "R3 R11 same-edge root, wrapped");
        translate(32'h002_04_00F, 1'b0, '0, "R3 R12 follow-up walk");
        drain();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule